// File: doc/BRIEF.md
# FM operator slot sequencer

This block is the time-division scheduler for an eight-voice synthesizer in which every voice has four operators. A five-bit slot counter runs freely from reset. There are thirty-two slots in each sample period. For the current slot the block decodes three values: the voice (channel) index, the operator role, and the global operator number. The operator datapath uses these values to fetch its state. The arithmetic of the operators is not part of this block.

The block also holds an 8-bit test register. That register provides four things:
- halt enables for the envelope stage, the phase stage (together with LFO amplitude modulation) and the LFO;
- a sign-inversion enable for the output data;
- a one-cycle LFO restart pulse, issued when the LFO halt is released;
- a debug readout mode.

In readout mode the 8-bit status bus carries one byte of the 16-bit internal word of a different slot in every cycle. When readout is off, the bus carries ordinary status flags.

Top module: `fm_slot_sequencer`

## Requirements
- R1: After reset `slot_idx` is 0. It advances by one on every clock edge and wraps from 31 back to 0.
- R2: `chan_idx` equals `slot_idx` mod 8.
- R3: `role` is 3 (C2) for slots 0–7, 0 (M1) for slots 8–15, 1 (M2) for slots 16–23 and 2 (C1) for slots 24–31.
- R4: `op_num` equals (`slot_idx` + 24) mod 32.
- R5: The test register resets to all zeros. A write takes effect only when `tr_wr_en` is high and `tr_addr` is 0x01; writes to any other address leave it unchanged. The halt outputs follow the register bits from the cycle after the write: bit 5 drives `eg_halt`, bit 3 drives `pg_am_halt`, bit 1 drives `lfo_halt` and bit 4 drives `neg_out`.
- R6: When bit 6 is set, `status_out` in the cycle after each clock edge holds one byte of the `slot_data` value captured at that edge. Bit 7 selects the byte: 0 gives bits 7:0 and 1 gives bits 15:8.
- R7: When bit 4 is set, the readout is taken from `slot_data` with bit 15 (its sign) inverted, and `neg_out` is high so that the converter stream can apply the same inversion.
- R8: When bit 6 is clear, `status_out` holds {5'b0, `busy`, `timer_b_flag`, `timer_a_flag`} captured at the previous edge.
- R9: `lfo_restart` is high for exactly one cycle after a write that clears bit 1 while bit 1 was set. Any other write leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tr_wr_en | input | 1 | Register write strobe |
| tr_addr | input | 8 | Register write address |
| tr_wdata | input | 8 | Register write data |
| slot_data | input | 16 | Internal word of the current slot |
| busy | input | 1 | Busy flag for normal status |
| timer_a_flag | input | 1 | Timer A overflow flag |
| timer_b_flag | input | 1 | Timer B overflow flag |
| slot_idx | output | 5 | Current slot |
| chan_idx | output | 3 | Channel of the current slot |
| role | output | 2 | Operator role code |
| op_num | output | 5 | Global operator number |
| status_out | output | 8 | Status or readout byte |
| eg_halt | output | 1 | Envelope stage halt |
| pg_am_halt | output | 1 | Phase stage and LFO AM halt |
| lfo_halt | output | 1 | LFO halt |
| lfo_restart | output | 1 | One-cycle LFO phase restart |
| neg_out | output | 1 | Output sign inversion enable |

## Verification
The slot, channel, role and operator outputs are pure decodes of the counter. They are compared in the same cycle against a bench count of the clock edges since reset. A register write is applied over one edge. The halt, sign and restart outputs are then sampled at the next falling edge, which is the first cycle after that write edge. The status bus has one cycle of latency. The driver therefore queues the expected byte at the falling edge where it applies the data. The monitor takes that byte from the queue a quarter period after the following rising edge, so each comparison lines up with the edge that captured the data.

// File: rtl/fm_slot_pkg.sv
package fm_slot_pkg;

  typedef enum logic [1:0] {
    ROLE_M1 = 2'd0,
    ROLE_M2 = 2'd1,
    ROLE_C1 = 2'd2,
    ROLE_C2 = 2'd3
  } op_role_e;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  // test register bit positions
  localparam int TBIT_LFO_HALT = 1;
  localparam int TBIT_PG_HALT  = 3;
  localparam int TBIT_NEG      = 4;
  localparam int TBIT_EG_HALT  = 5;
  localparam int TBIT_RD_EN    = 6;
  localparam int TBIT_BYTE_HI  = 7;

  function automatic int unsigned chan_of(int unsigned s, int unsigned n_ch);
    return s % n_ch;
  endfunction

  function automatic int unsigned op_of(int unsigned s, int unsigned off, int unsigned n);
    return (s + off) % n;
  endfunction

  // slot groups run C2, M1, M2, C1: role code is group index plus 3, mod 4
  function automatic op_role_e role_of(int unsigned s, int unsigned grp);
    logic [1:0] g;
    g = 2'((s / grp) + 3);
    return op_role_e'(g);
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(logic [WORD_W-1:0] d, logic hi, logic neg);
    logic [WORD_W-1:0] v;
    v = d ^ {neg, {(WORD_W-1){1'b0}}};
    return hi ? v[WORD_W-1 -: BYTE_W] : v[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/fm_slot_counter.sv
module fm_slot_counter #(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  logic at_last;
  assign at_last = (slot == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       slot <= '0;
    else if (at_last) slot <= '0;
    else              slot <= slot + 1'b1;
  end

  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> slot == '0);
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    !at_last |=> slot == SLOT_W'($past(slot) + 1'b1));

endmodule

// File: rtl/fm_test_reg.sv
module fm_test_reg #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        treg,
  output logic              lfo_restart
);
  import fm_slot_pkg::*;

  logic hit;
  logic lfo_release;
  assign hit         = wr_en && (addr == REG_ADDR);
  assign lfo_release = hit && treg[TBIT_LFO_HALT] && !wdata[TBIT_LFO_HALT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      treg        <= '0;
      lfo_restart <= 1'b0;
    end else begin
      if (hit) treg <= wdata;
      lfo_restart <= lfo_release;
    end
  end

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(treg));
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    lfo_restart |-> (!treg[TBIT_LFO_HALT] && $past(treg[TBIT_LFO_HALT])));
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    lfo_restart |=> !lfo_restart);

endmodule

// File: rtl/fm_readout.sv
module fm_readout (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_en,
  input  logic                            hi_sel,
  input  logic                            neg,
  input  logic [fm_slot_pkg::WORD_W-1:0]  slot_data,
  input  logic                            busy,
  input  logic                            timer_a_flag,
  input  logic                            timer_b_flag,
  output logic [fm_slot_pkg::BYTE_W-1:0]  status_out
);
  import fm_slot_pkg::*;

  logic [BYTE_W-1:0] rd_byte;
  logic [BYTE_W-1:0] norm_byte;
  assign rd_byte   = pick_byte(slot_data, hi_sel, neg);
  assign norm_byte = {{(BYTE_W-3){1'b0}}, busy, timer_b_flag, timer_a_flag};

  always_ff @(posedge clk) begin
    if (!rst_n) status_out <= '0;
    else        status_out <= rd_en ? rd_byte : norm_byte;
  end

  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> status_out == {5'b0, $past(busy), $past(timer_b_flag), $past(timer_a_flag)});
  a_r6_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hi_sel && !neg) |=> status_out == $past(slot_data[15:8]));
  a_r7_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hi_sel && neg) |=> status_out[7] != $past(slot_data[15]));

endmodule

// File: rtl/fm_slot_sequencer.sv
module fm_slot_sequencer #(
  parameter int NUM_SLOTS  = 32,
  parameter int NUM_CHANS  = 8,
  parameter int OP_OFFSET  = 24,
  parameter int ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] TEST_ADDR = 8'h01,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int CH_W   = $clog2(NUM_CHANS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tr_wr_en,
  input  logic [ADDR_W-1:0] tr_addr,
  input  logic [7:0]        tr_wdata,
  input  logic [15:0]       slot_data,
  input  logic              busy,
  input  logic              timer_a_flag,
  input  logic              timer_b_flag,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [CH_W-1:0]   chan_idx,
  output logic [1:0]        role,
  output logic [SLOT_W-1:0] op_num,
  output logic [7:0]        status_out,
  output logic              eg_halt,
  output logic              pg_am_halt,
  output logic              lfo_halt,
  output logic              lfo_restart,
  output logic              neg_out
);
  import fm_slot_pkg::*;

  logic [7:0] treg;
  op_role_e   role_e;

  fm_slot_counter #(.NUM_SLOTS(NUM_SLOTS)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .slot (slot_idx)
  );

  always_comb begin
    chan_idx = CH_W'(chan_of(32'(slot_idx), NUM_CHANS));
    op_num   = SLOT_W'(op_of(32'(slot_idx), OP_OFFSET, NUM_SLOTS));
    role_e   = role_of(32'(slot_idx), NUM_CHANS);
    role     = role_e;
  end

  fm_test_reg #(.ADDR_W(ADDR_W), .REG_ADDR(TEST_ADDR)) u_treg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (tr_wr_en),
    .addr       (tr_addr),
    .wdata      (tr_wdata),
    .treg       (treg),
    .lfo_restart(lfo_restart)
  );

  assign eg_halt    = treg[TBIT_EG_HALT];
  assign pg_am_halt = treg[TBIT_PG_HALT];
  assign lfo_halt   = treg[TBIT_LFO_HALT];
  assign neg_out    = treg[TBIT_NEG];

  fm_readout u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (treg[TBIT_RD_EN]),
    .hi_sel      (treg[TBIT_BYTE_HI]),
    .neg         (treg[TBIT_NEG]),
    .slot_data   (slot_data),
    .busy        (busy),
    .timer_a_flag(timer_a_flag),
    .timer_b_flag(timer_b_flag),
    .status_out  (status_out)
  );

  a_r4_op_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> op_num == SLOT_W'($past(op_num) + 1'b1));
  a_r3_role_op: assert property (@(posedge clk) disable iff (!rst_n)
    role == op_num[SLOT_W-1 -: 2]);
  a_r2_chan_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> chan_idx == CH_W'($past(chan_idx) + 1'b1));

endmodule

// File: tb/fm_slot_sequencer_tb.sv
module fm_slot_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tr_wr_en = 1'b0;
  logic [7:0] tr_addr = '0;
  logic [7:0] tr_wdata = '0;
  logic [15:0] slot_data = '0;
  logic busy = 1'b0, timer_a_flag = 1'b0, timer_b_flag = 1'b0;
  logic [4:0] slot_idx, op_num;
  logic [2:0] chan_idx;
  logic [1:0] role;
  logic [7:0] status_out;
  logic eg_halt, pg_am_halt, lfo_halt, lfo_restart, neg_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] tr_m = '0;
  int slot_m = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_slot_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .tr_wr_en(tr_wr_en), .tr_addr(tr_addr),
    .tr_wdata(tr_wdata), .slot_data(slot_data), .busy(busy),
    .timer_a_flag(timer_a_flag), .timer_b_flag(timer_b_flag),
    .slot_idx(slot_idx), .chan_idx(chan_idx), .role(role), .op_num(op_num),
    .status_out(status_out), .eg_halt(eg_halt), .pg_am_halt(pg_am_halt),
    .lfo_halt(lfo_halt), .lfo_restart(lfo_restart), .neg_out(neg_out)
  );

  always @(posedge clk) if (rst_n) slot_m = (slot_m + 1) % 32;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tr_wr_en = 1'b1; tr_addr = a; tr_wdata = d;
    @(negedge clk);
    tr_wr_en = 1'b0;
    if (a == 8'h01) tr_m = d;
  endtask

  function automatic logic [7:0] model_status(logic [15:0] d, logic b, logic ta, logic tb);
    logic [15:0] v;
    if (!tr_m[6]) return {5'b0, b, tb, ta};
    v = tr_m[4] ? (d ^ 16'h8000) : d;
    return tr_m[7] ? v[15:8] : v[7:0];
  endfunction

  task automatic push_item(input logic [15:0] d, input logic b, input logic ta,
                           input logic tb, input string tag);
    @(negedge clk);
    slot_data = d; busy = b; timer_a_flag = ta; timer_b_flag = tb;
    exp_q.push_back(model_status(d, b, ta, tb));
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
  endtask

  task automatic check_halts(input string req);
    check(eg_halt == tr_m[5], req, eg_halt, tr_m[5]);
    check(pg_am_halt == tr_m[3], req, pg_am_halt, tr_m[3]);
    check(lfo_halt == tr_m[1], req, lfo_halt, tr_m[1]);
    check(neg_out == tr_m[4], req, neg_out, tr_m[4]);
  endtask

  // monitor: compares one queued item a quarter period after each rising edge
  initial begin
    forever begin
      logic [7:0] e;
      string t;
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(status_out == e, t, status_out, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check(slot_idx == 0, "R1 reset", slot_idx, 0);
    check(status_out == 0, "R8 reset", status_out, 0);
    check_halts("R5 reset");
    check(lfo_restart == 0, "R9 reset", lfo_restart, 0);
    rst_n = 1'b1;

    // counter and decodes over more than two sample periods
    for (int i = 0; i < 70; i++) begin
      int er;
      @(negedge clk);
      if (slot_m < 8) er = 3; else if (slot_m < 16) er = 0;
      else if (slot_m < 24) er = 1; else er = 2;
      check(slot_idx == slot_m[4:0], "R1 slot", slot_idx, slot_m);
      check(chan_idx == slot_m % 8, "R2 chan", chan_idx, slot_m % 8);
      check(role == er[1:0], "R3 role", role, er);
      check(op_num == (slot_m + 24) % 32, "R4 op", op_num, (slot_m + 24) % 32);
    end

    // normal status patterns
    push_item(16'h1234, 1, 0, 0, "R8 busy");
    push_item(16'hFFFF, 0, 1, 0, "R8 timer a");
    push_item(16'h0000, 0, 0, 1, "R8 timer b");
    push_item(16'hABCD, 1, 1, 1, "R8 all");
    drain();

    // write to other address ignored
    wr(8'h02, 8'hFF);
    tr_m = 8'h00;
    check_halts("R5 other address");
    check(lfo_restart == 0, "R9 other address", lfo_restart, 0);
    push_item(16'h5AA5, 0, 1, 1, "R5 readout still off");
    drain();

    // halts on
    wr(8'h01, 8'b0010_1010);
    check_halts("R5 halts set");
    check(lfo_restart == 0, "R9 no restart on set", lfo_restart, 0);

    // readout low byte, LFO released
    wr(8'h01, 8'h40);
    check(lfo_restart == 1, "R9 restart pulse", lfo_restart, 1);
    check_halts("R5 halts cleared");
    @(negedge clk);
    check(lfo_restart == 0, "R9 pulse width", lfo_restart, 0);
    push_item(16'h1234, 0, 0, 0, "R6 low byte");
    push_item(16'hBEEF, 1, 1, 1, "R6 low byte");
    push_item(16'h80FF, 0, 0, 0, "R6 low byte");
    drain();

    // high byte
    wr(8'h01, 8'hC0);
    push_item(16'h1234, 0, 0, 0, "R6 high byte");
    push_item(16'hBEEF, 0, 0, 0, "R6 high byte");
    push_item(16'h7F00, 0, 0, 0, "R6 high byte");
    drain();

    // sign inversion, high byte
    wr(8'h01, 8'hD0);
    check_halts("R7 neg_out");
    push_item(16'h1234, 0, 0, 0, "R7 neg high");
    push_item(16'hF00D, 0, 0, 0, "R7 neg high");
    drain();

    // sign inversion, low byte unaffected
    wr(8'h01, 8'h50);
    push_item(16'h8077, 0, 0, 0, "R7 neg low");
    drain();

    // back to normal; bit1 was clear so no pulse
    wr(8'h01, 8'h00);
    check(lfo_restart == 0, "R9 no pulse", lfo_restart, 0);
    check_halts("R5 cleared");
    push_item(16'hFFFF, 1, 0, 1, "R8 after readout");
    drain();

    finish_run();
  end
endmodule